// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces, for every common and every segment pin of a multiplexed passive LCD, a small level code that picks one rail of an external resistor-ladder voltage divider. A level code of `k` means `k/D` of the panel supply, where `D` is the denominator of the selected bias. The analog ladder and the pin buffers sit outside the block and turn each code into a voltage.

A frame is a series of phases, one per active common. The frequency generator advances the sequence with a single-cycle `phase_tick`. In each phase one common is selected and driven to a full-scale rail. The other active commons sit on intermediate rails. Each segment takes one of two levels, depending on the pixel bit that the display buffer supplies for the current phase on `seg_pix`. Frames alternate between odd and even. Every level is mirrored (`k` becomes `D-k`) in even frames, so each pixel sees no net DC.

After the last phase of each frame, a programmable number of dead phases can follow. In a dead phase every output sits at ground, which lowers the RMS drive and so sets contrast. Duty, bias and dead-time settings are taken in while the block is disabled and again at each frame boundary.

Top module: `lcd_wave_seq`

## Requirements
- R1: While `rst_n` is low, or after a clock edge with `enable` low, every common and segment code is 0, `phase_idx` is 0, `frame_odd` is 1 and `in_dead` is 0. Ticks arriving while disabled leave this state unchanged.
- R2: While enabled, each `phase_tick` advances `phase_idx` by one, and no state changes without a tick. The number of phases per frame comes from `duty_sel`: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, and 4 gives 8.
- R3: The first frame after `enable` rises is odd (`frame_odd`=1). Parity flips at every frame boundary.
- R4: The common whose index equals `phase_idx` is driven to `D` in odd frames and to 0 in even frames. `D` comes from `bias_sel`: 0 gives 1 (static), 1 gives 2, 2 gives 3, and 3 gives 4.
- R5: An active common that is not selected (its index is below the phase count) is driven to 1 in odd frames and to `D-1` in even frames. With static bias it is driven to 0 and 1 instead. Commons whose index is at or above the phase count stay at 0.
- R6: A segment whose `seg_pix` bit is 1 is driven to 0 in odd frames and to `D` in even frames. A segment whose bit is 0 is driven to `min(2,D)` in odd frames and to `D-min(2,D)` in even frames. The segment codes follow `seg_pix` within the same cycle.
- R7: After the last phase of a frame, `dead_sel` tick periods follow in which `in_dead`=1, all codes are 0 and `phase_idx` holds the last phase. Values of `dead_sel` above 8 count as 8, and a value of 0 inserts no dead phase.
- R8: Changes to `duty_sel`, `bias_sel` or `dead_sel` while enabled take effect only when the next frame starts.
- R9: The reserved `duty_sel` codes 5, 6 and 7 behave as static duty (one phase per frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the sequencer; when low, outputs are at ground and the sequence restarts |
| phase_tick | input | 1 | One-cycle pulse that advances one phase period |
| duty_sel | input | 3 | Duty code (0 static, 1 half, 2 third, 3 quarter, 4 eighth) |
| bias_sel | input | 2 | Bias code (0 static, 1 half, 2 third, 3 quarter) |
| dead_sel | input | 4 | Dead phases inserted after each frame, 0 to 8 |
| seg_pix | input | 8 | Pixel bits of the current phase, one per segment |
| com_lvl | output | 24 | Common level codes, 3 bits per common, common c at bits 3c+2:3c |
| seg_lvl | output | 24 | Segment level codes, 3 bits per segment, segment s at bits 3s+2:3s |
| phase_idx | output | 3 | Current phase; selects the pixel row to present on `seg_pix` |
| frame_odd | output | 1 | 1 during odd frames |
| in_dead | output | 1 | 1 during a dead phase |

## Verification
The phase counter, the frame parity and the dead flag are registered. A tick therefore shows up in `phase_idx`, `frame_odd`, `in_dead` and all the codes just after the clock edge that samples it. The codes are a combinational function of that state and of `seg_pix`, so a new pixel pattern is visible in the same cycle it is applied. The bench changes inputs shortly after a rising edge and pushes the expected codes into a queue at that moment. A monitor pops and compares them at the following falling edge, which is one edge after the tick for the registered fields and zero edges after the pixel change for the segment codes. Setting changes are made in the middle of a frame, and the expected sequence keeps the old phase count until its own frame-position counter wraps.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int LVL_W = 3;

  typedef enum logic [2:0] {
    DUTY_STATIC  = 3'd0,
    DUTY_HALF    = 3'd1,
    DUTY_THIRD   = 3'd2,
    DUTY_QUARTER = 3'd3,
    DUTY_EIGHTH  = 3'd4
  } duty_e;

  // phases in one frame for a duty code; reserved codes run as static
  function automatic logic [3:0] phases_of(input logic [2:0] code);
    case (code)
      DUTY_HALF:    phases_of = 4'd2;
      DUTY_THIRD:   phases_of = 4'd3;
      DUTY_QUARTER: phases_of = 4'd4;
      DUTY_EIGHTH:  phases_of = 4'd8;
      default:      phases_of = 4'd1;
    endcase
  endfunction

  // full-scale code (bias denominator); static bias uses 1
  function automatic logic [LVL_W-1:0] den_of(input logic [1:0] code);
    if (code == 2'd0) den_of = LVL_W'(1);
    else              den_of = LVL_W'(code) + LVL_W'(1);
  endfunction

  // even frames mirror every level about the ladder midpoint
  function automatic logic [LVL_W-1:0] mirror(input logic odd,
                                              input logic [LVL_W-1:0] den,
                                              input logic [LVL_W-1:0] lvl);
    mirror = odd ? lvl : den - lvl;
  endfunction

  function automatic logic [LVL_W-1:0] com_level(input logic sel,
                                                 input logic odd,
                                                 input logic [LVL_W-1:0] den);
    logic [LVL_W-1:0] base;
    if (sel)                    base = den;
    else if (den == LVL_W'(1))  base = '0;
    else                        base = LVL_W'(1);
    com_level = mirror(odd, den, base);
  endfunction

  function automatic logic [LVL_W-1:0] seg_level(input logic on,
                                                 input logic odd,
                                                 input logic [LVL_W-1:0] den);
    logic [LVL_W-1:0] base;
    if (on)                     base = '0;
    else if (den < LVL_W'(2))   base = den;
    else                        base = LVL_W'(2);
    seg_level = mirror(odd, den, base);
  endfunction

endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int PH_W     = 3,
  parameter int DT_W     = 4,
  parameter int MAX_DEAD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             phase_tick,
  input  logic [2:0]       duty_sel,
  input  logic [1:0]       bias_sel,
  input  logic [DT_W-1:0]  dead_sel,
  output logic [PH_W-1:0]  phase_idx,
  output logic [PH_W:0]    nph,
  output logic [LVL_W-1:0] den,
  output logic             frame_odd,
  output logic             in_dead
);

  localparam logic [DT_W-1:0] DEAD_CAP = DT_W'(MAX_DEAD);

  logic [2:0]      duty_q;
  logic [1:0]      bias_q;
  logic [DT_W-1:0] dlim_q, dcnt_q, dlim_in;
  logic [PH_W-1:0] phase_q;
  logic            odd_q, dead_q;

  // named events for the assertions
  logic last_ph, frame_wrap, dead_enter, dead_done;

  assign nph       = (PH_W+1)'(phases_of(duty_q));
  assign den       = den_of(bias_q);
  assign dlim_in   = (dead_sel > DEAD_CAP) ? DEAD_CAP : dead_sel;
  assign last_ph   = ({1'b0, phase_q} == nph - 1'b1);
  assign dead_done = dead_q && (dcnt_q == dlim_q);
  assign frame_wrap = enable && phase_tick &&
                      ((!dead_q && last_ph && dlim_q == '0) || dead_done);
  assign dead_enter = enable && phase_tick && !dead_q && last_ph && dlim_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      odd_q   <= 1'b1;
      dead_q  <= 1'b0;
      dcnt_q  <= '0;
      duty_q  <= '0;
      bias_q  <= '0;
      dlim_q  <= '0;
    end else if (!enable || frame_wrap) begin
      phase_q <= '0;
      odd_q   <= enable ? ~odd_q : 1'b1;
      dead_q  <= 1'b0;
      dcnt_q  <= '0;
      duty_q  <= duty_sel;
      bias_q  <= bias_sel;
      dlim_q  <= dlim_in;
    end else if (phase_tick) begin
      if (dead_enter) begin
        dead_q <= 1'b1;
        dcnt_q <= DT_W'(1);
      end else if (dead_q) begin
        dcnt_q <= dcnt_q + DT_W'(1);
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  assign phase_idx = phase_q;
  assign frame_odd = odd_q;
  assign in_dead   = dead_q;

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !dead_q) |-> ({1'b0, phase_q} < nph));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase_tick && !dead_q && !last_ph) |=> (phase_q == $past(phase_q) + PH_W'(1)));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !phase_tick) |=> ($stable(phase_q) && $stable(odd_q) && $stable(dead_q)));

  assert_parity_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (odd_q != $past(odd_q)));

  assert_dead_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |-> (dcnt_q <= dlim_q && dlim_q != '0 && dlim_q <= DEAD_CAP));

  assert_settings_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !frame_wrap) |=> ($stable(duty_q) && $stable(bias_q) && $stable(dlim_q)));

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_seq_pkg::*;
#(
  parameter int N_COM = 8,
  parameter int PH_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   in_dead,
  input  logic                   frame_odd,
  input  logic [PH_W-1:0]        phase_idx,
  input  logic [PH_W:0]          nph,
  input  logic [LVL_W-1:0]       den,
  output logic [N_COM*LVL_W-1:0] com_lvl
);

  logic [N_COM-1:0] sel_mask;
  logic [N_COM-1:0] act_mask;

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    assign act_mask[c] = ((PH_W+1)'(c) < nph);
    assign sel_mask[c] = act_mask[c] && (phase_idx == PH_W'(c));

    always_comb begin
      if (!enable || in_dead || !act_mask[c])
        com_lvl[c*LVL_W +: LVL_W] = '0;
      else
        com_lvl[c*LVL_W +: LVL_W] = com_level(sel_mask[c], frame_odd, den);
    end

    assert_com_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      com_lvl[c*LVL_W +: LVL_W] <= den);
  end

  assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_mask));

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_seq_pkg::*;
#(
  parameter int N_SEG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   in_dead,
  input  logic                   frame_odd,
  input  logic [LVL_W-1:0]       den,
  input  logic [N_SEG-1:0]       seg_pix,
  output logic [N_SEG*LVL_W-1:0] seg_lvl
);

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    always_comb begin
      if (!enable || in_dead)
        seg_lvl[s*LVL_W +: LVL_W] = '0;
      else
        seg_lvl[s*LVL_W +: LVL_W] = seg_level(seg_pix[s], frame_odd, den);
    end

    assert_seg_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seg_lvl[s*LVL_W +: LVL_W] <= den);
  end

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int N_COM    = 8,
  parameter int N_SEG    = 8,
  parameter int DT_W     = 4,
  parameter int MAX_DEAD = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       phase_tick,
  input  logic [2:0]                 duty_sel,
  input  logic [1:0]                 bias_sel,
  input  logic [DT_W-1:0]            dead_sel,
  input  logic [N_SEG-1:0]           seg_pix,
  output logic [N_COM*LVL_W-1:0]     com_lvl,
  output logic [N_SEG*LVL_W-1:0]     seg_lvl,
  output logic [$clog2(N_COM)-1:0]   phase_idx,
  output logic                       frame_odd,
  output logic                       in_dead
);

  localparam int PH_W = $clog2(N_COM);

  logic [PH_W:0]      nph;
  logic [LVL_W-1:0]   den;

  lcd_phase_ctrl #(.PH_W(PH_W), .DT_W(DT_W), .MAX_DEAD(MAX_DEAD)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .phase_tick (phase_tick),
    .duty_sel   (duty_sel),
    .bias_sel   (bias_sel),
    .dead_sel   (dead_sel),
    .phase_idx  (phase_idx),
    .nph        (nph),
    .den        (den),
    .frame_odd  (frame_odd),
    .in_dead    (in_dead)
  );

  lcd_com_drv #(.N_COM(N_COM), .PH_W(PH_W)) u_com (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .in_dead   (in_dead),
    .frame_odd (frame_odd),
    .phase_idx (phase_idx),
    .nph       (nph),
    .den       (den),
    .com_lvl   (com_lvl)
  );

  lcd_seg_drv #(.N_SEG(N_SEG)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .in_dead   (in_dead),
    .frame_odd (frame_odd),
    .den       (den),
    .seg_pix   (seg_pix),
    .seg_lvl   (seg_lvl)
  );

  assert_dead_all_vss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_dead |-> (com_lvl == '0 && seg_lvl == '0));

  assert_selected_full_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !in_dead) |->
      (com_lvl[phase_idx*LVL_W +: LVL_W] == (frame_odd ? den : LVL_W'(0))));

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (com_lvl == '0 && seg_lvl == '0));

endmodule

// File: tb/test_lcd_wave_seq.sv
module test_lcd_wave_seq;

  localparam int NC = 8;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        phase_tick = 1'b0;
  logic [2:0]  duty_sel = '0;
  logic [1:0]  bias_sel = '0;
  logic [3:0]  dead_sel = '0;
  logic [NS-1:0] seg_pix = '0;
  logic [NC*3-1:0] com_lvl;
  logic [NS*3-1:0] seg_lvl;
  logic [2:0]  phase_idx;
  logic        frame_odd, in_dead;

  always #2.5 clk = ~clk;

  lcd_wave_seq i_lcd_wave_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_tick(phase_tick),
    .duty_sel(duty_sel), .bias_sel(bias_sel), .dead_sel(dead_sel),
    .seg_pix(seg_pix), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .phase_idx(phase_idx), .frame_odd(frame_odd), .in_dead(in_dead)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model: position within the frame including dead slots
  bit m_en = 0;
  int m_pos = 0;
  bit m_odd = 1;
  int m_nph = 1, m_den = 1, m_dlim = 0;

  logic [NC*3-1:0] q_com[$];
  logic [NS*3-1:0] q_seg[$];
  logic [2:0]      q_ph[$];
  logic            q_odd[$];
  logic            q_dead[$];
  string           q_tag[$];

  function automatic int duty_phases(input logic [2:0] d);
    case (d)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int bias_full(input logic [1:0] b);
    case (b)
      2'd1: return 2;
      2'd2: return 3;
      2'd3: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic model_latch();
    m_nph  = duty_phases(duty_sel);
    m_den  = bias_full(bias_sel);
    m_dlim = (dead_sel > 8) ? 8 : int'(dead_sel);
  endtask

  task automatic push_expect(input string tag);
    logic [NC*3-1:0] ec;
    logic [NS*3-1:0] es;
    bit dead;
    int ph, lo;
    dead = m_en && (m_pos >= m_nph);
    ph = (!m_en) ? 0 : (dead ? m_nph - 1 : m_pos);
    ec = '0;
    es = '0;
    if (m_en && !dead) begin
      for (int c = 0; c < NC; c++) begin
        int v;
        if (c >= m_nph) v = 0;
        else if (c == ph) v = m_odd ? m_den : 0;
        else if (m_odd) v = (m_den > 1) ? 1 : 0;
        else v = (m_den > 1) ? m_den - 1 : 1;
        ec[c*3 +: 3] = 3'(v);
      end
      lo = (m_den >= 2) ? 2 : m_den;
      for (int s = 0; s < NS; s++) begin
        int v;
        if (seg_pix[s]) v = m_odd ? 0 : m_den;
        else            v = m_odd ? lo : m_den - lo;
        es[s*3 +: 3] = 3'(v);
      end
    end
    q_com.push_back(ec);
    q_seg.push_back(es);
    q_ph.push_back(3'(ph));
    q_odd.push_back(m_en ? m_odd : 1'b1);
    q_dead.push_back(dead);
    q_tag.push_back(tag);
  endtask

  // monitor: compares half a cycle after the expectation was queued
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      logic [NC*3-1:0] ec;
      logic [NS*3-1:0] es;
      logic [2:0] eph;
      logic eo, ed;
      string t;
      ec = q_com.pop_front();
      es = q_seg.pop_front();
      eph = q_ph.pop_front();
      eo = q_odd.pop_front();
      ed = q_dead.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (com_lvl !== ec || seg_lvl !== es || phase_idx !== eph ||
          frame_odd !== eo || in_dead !== ed) begin
        failures++;
        $display("FAIL %s actual com=%h seg=%h ph=%0d odd=%0b dead=%0b expected com=%h seg=%h ph=%0d odd=%0b dead=%0b",
                 t, com_lvl, seg_lvl, phase_idx, frame_odd, in_dead,
                 ec, es, eph, eo, ed);
      end
    end
  end

  task automatic hold(input logic [NS-1:0] pix, input string tag);
    @(posedge clk);
    #1;
    seg_pix = pix;
    push_expect(tag);
  endtask

  task automatic do_tick(input logic [NS-1:0] pix, input string tag);
    @(posedge clk);
    #1;
    phase_tick = 1'b1;
    seg_pix = pix;
    @(posedge clk);
    #1;
    phase_tick = 1'b0;
    if (m_en) begin
      if (m_pos == m_nph + m_dlim - 1) begin
        m_pos = 0;
        m_odd = ~m_odd;
        model_latch();
      end else begin
        m_pos++;
      end
    end
    push_expect(tag);
  endtask

  task automatic start(input logic [2:0] d, input logic [1:0] b,
                       input logic [3:0] dt, input string tag);
    @(posedge clk);
    #1;
    enable = 1'b0;
    duty_sel = d;
    bias_sel = b;
    dead_sel = dt;
    @(posedge clk);
    #1;
    enable = 1'b1;
    m_en = 1;
    m_pos = 0;
    m_odd = 1;
    model_latch();
    push_expect(tag);
  endtask

  task automatic run_ticks(input int n, input int seed, input string tag);
    for (int k = 0; k < n; k++) do_tick(NS'(k * 37 + seed), tag);
  endtask

  initial begin
    // R1: reset state
    hold(8'hFF, "R1");
    hold(8'h5A, "R1");
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    hold(8'h0F, "R1");

    // R3 first odd frame; R4 R5 R6 quarter duty, third bias
    start(3'd3, 2'd2, 4'd0, "R3");
    run_ticks(8, 5, "R2 R4 R5 R6");
    hold(8'hFF, "R2 R6");
    hold(8'h00, "R2 R6");

    // R7 with eighth duty, quarter bias, two dead phases
    start(3'd4, 2'd3, 4'd2, "R3");
    run_ticks(22, 11, "R2 R4 R5 R7");

    // R8: settings changed mid-frame take effect at the next frame
    start(3'd3, 2'd1, 4'd1, "R3");
    do_tick(8'hC3, "R8");
    duty_sel = 3'd1;
    bias_sel = 2'd3;
    dead_sel = 4'd0;
    run_ticks(10, 3, "R8");

    // static duty and bias: parity flips every tick
    start(3'd0, 2'd0, 4'd0, "R3");
    run_ticks(4, 1, "R3 R5 R6");

    // R7 clamp: 12 requested, 8 inserted
    start(3'd1, 2'd2, 4'd12, "R3");
    run_ticks(14, 7, "R7");

    // R1: ticks while disabled are ignored
    @(posedge clk);
    #1;
    enable = 1'b0;
    m_en = 0;
    m_pos = 0;
    m_odd = 1;
    run_ticks(3, 9, "R1");

    // third duty with dead phases
    start(3'd2, 2'd2, 4'd3, "R3");
    run_ticks(14, 2, "R2 R5 R7");

    // R9: reserved duty code runs as static
    start(3'd6, 2'd1, 4'd0, "R9");
    run_ticks(3, 4, "R9");

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule